// File: doc/BRIEF.md
# Four-Mode Bidirectional Shift Register

This block is a small register, four bits wide by default, that on every rising clock edge does one of four things: keeps its contents, moves every bit one place toward the least significant end, moves every bit one place toward the most significant end, or takes a whole new word from its parallel input. A 2-bit mode input picks the operation. Each end has a serial input that fills the vacated bit during a shift. The register contents appear on a parallel output. The two end bits are also brought out on their own, so a chain of units can be built by wiring one unit's end bit to the neighbour's serial input.

A clear input returns the register to all zeros on the next rising edge, whatever the mode input says. Clear is sampled on the clock like every other input, so the block has a single timing domain and no level-sensitive path into the flops.

Top module: `bidir_shift_reg`

## Requirements
- R1: With clear low and mode 2'b00, the contents after the edge equal the contents before it.
- R2: With clear low and mode 2'b01, bit i takes the old bit i+1 for i below WIDTH-1, and the most significant bit takes `leftIn`.
- R3: With clear low and mode 2'b10, bit i takes the old bit i-1 for i above 0, and bit 0 takes `rightIn`.
- R4: With clear low and mode 2'b11, the contents after the edge equal `parIn` as sampled at that edge.
- R5: With clear high at a rising edge, every bit is zero after that edge, for all four mode values and any data inputs.
- R6: `leftOut` always equals the most significant bit of `parOut`, and `rightOut` always equals bit 0 of `parOut`.
- R7: After clear is released, mode 2'b00 cycles keep the contents at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear | input | 1 | Synchronous clear to zero, dominates the mode |
| mode | input | 2 | 00 keep, 01 shift toward bit 0, 10 shift toward the top bit, 11 parallel load |
| parIn | input | WIDTH | Word taken in mode 11 |
| leftIn | input | 1 | Serial bit entering the top position in mode 01 |
| rightIn | input | 1 | Serial bit entering bit 0 in mode 10 |
| parOut | output | WIDTH | Register contents |
| leftOut | output | 1 | Top bit of the register |
| rightOut | output | 1 | Bit 0 of the register |

## Verification
Clear and an active mode (a load or a shift with a set serial input) can land on the same edge, and only the clear may take effect. The bench first fills the register with a nonzero word, then raises clear together with each of the four mode values and ones on every data input, and also mixes clear into a long random run of modes. A queue-based model that applies clear before looking at the mode judges each such cycle, so any leak of load or shift data through a clear shows as a nonzero bit.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic [1:0] {
    MODE_KEEP   = 2'b00,
    MODE_TOLOW  = 2'b01,
    MODE_TOHIGH = 2'b10,
    MODE_LOAD   = 2'b11
  } mode_e;

  // One strobe per operation; exactly one is high each cycle.
  typedef struct packed {
    logic zero;
    logic keep;
    logic toLow;
    logic toHigh;
    logic load;
  } strobes_t;

endpackage

// File: rtl/bsr_control.sv
module bsr_control
  import bsr_pkg::*;
(
  input  logic     clear,
  input  mode_e    mode,
  output strobes_t str
);

  always_comb begin
    str = '0;
    if (clear) begin
      str.zero = 1'b1;
    end else begin
      unique case (mode)
        MODE_KEEP:   str.keep   = 1'b1;
        MODE_TOLOW:  str.toLow  = 1'b1;
        MODE_TOHIGH: str.toHigh = 1'b1;
        MODE_LOAD:   str.load   = 1'b1;
        default:     str.keep   = 1'b1;
      endcase
    end
  end

  // R5: clear wins over every mode; one operation at a time
  always_comb begin
    assert_onehot_strobe_R5 : assert ($onehot(str));
    if (clear) begin
      assert_clear_dominates_R5 : assert (str.zero);
    end
  end

endmodule

// File: rtl/bsr_cell.sv
module bsr_cell
  import bsr_pkg::*;
(
  input  logic     clk,
  input  strobes_t str,
  input  logic     upperQ,
  input  logic     lowerQ,
  input  logic     parBit,
  output logic     q
);

  logic nxt;

  always_comb begin
    nxt = q;
    if (str.zero)        nxt = 1'b0;
    else if (str.load)   nxt = parBit;
    else if (str.toLow)  nxt = upperQ;
    else if (str.toHigh) nxt = lowerQ;
    else if (str.keep)   nxt = q;
  end

  always_ff @(posedge clk) begin
    q <= nxt;
  end

endmodule

// File: rtl/bsr_datapath.sv
module bsr_datapath
  import bsr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  strobes_t         str,
  input  logic [WIDTH-1:0] parIn,
  input  logic             leftIn,
  input  logic             rightIn,
  output logic [WIDTH-1:0] q
);

  localparam int EXT_W = WIDTH + 2;

  // Register padded with the serial inputs so every cell sees two neighbours.
  logic [EXT_W-1:0] ext;
  assign ext = {leftIn, q, rightIn};

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    bsr_cell u_cell (
      .clk    (clk),
      .str    (str),
      .upperQ (ext[g+2]),
      .lowerQ (ext[g]),
      .parBit (parIn[g]),
      .q      (q[g])
    );
  end

  // R5: clear empties the register on the next edge
  assert_clear_zero_R5 : assert property (@(posedge clk)
    str.zero |=> (q == '0));

  // R1: keep leaves the contents unchanged
  assert_keep_stable_R1 : assert property (@(posedge clk) disable iff (str.zero)
    str.keep |=> (q == $past(q)));

  // R2: shift toward bit 0, top filled from leftIn
  assert_shift_low_R2 : assert property (@(posedge clk) disable iff (str.zero)
    str.toLow |=> (q == {$past(leftIn), $past(q[WIDTH-1:1])}));

  // R3: shift toward the top, bit 0 filled from rightIn
  assert_shift_high_R3 : assert property (@(posedge clk) disable iff (str.zero)
    str.toHigh |=> (q == {$past(q[WIDTH-2:0]), $past(rightIn)}));

  // R4: parallel load
  assert_load_word_R4 : assert property (@(posedge clk) disable iff (str.zero)
    str.load |=> (q == $past(parIn)));

endmodule

// File: rtl/bidir_shift_reg.sv
module bidir_shift_reg
  import bsr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clear,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] parIn,
  input  logic             leftIn,
  input  logic             rightIn,
  output logic [WIDTH-1:0] parOut,
  output logic             leftOut,
  output logic             rightOut
);

  strobes_t str;

  bsr_control u_control (
    .clear (clear),
    .mode  (mode_e'(mode)),
    .str   (str)
  );

  bsr_datapath #(.WIDTH(WIDTH)) u_datapath (
    .clk     (clk),
    .str     (str),
    .parIn   (parIn),
    .leftIn  (leftIn),
    .rightIn (rightIn),
    .q       (parOut)
  );

  // R6: end bits exposed for chaining
  assign leftOut  = parOut[WIDTH-1];
  assign rightOut = parOut[0];

endmodule

// File: tb/bidir_shift_reg_tb.sv
module bidir_shift_reg_tb_top;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         clear = 1'b1;
  logic [1:0]   mode = 2'b00;
  logic [W-1:0] parIn = '0;
  logic         leftIn = 1'b0;
  logic         rightIn = 1'b0;
  logic [W-1:0] parOut;
  logic         leftOut;
  logic         rightOut;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // Reference: queue of bits, index 0 is bit 0.
  bit mdl[$];

  always #10 clk = ~clk;

  bidir_shift_reg #(.WIDTH(W)) dut_i (
    .clk(clk), .clear(clear), .mode(mode), .parIn(parIn),
    .leftIn(leftIn), .rightIn(rightIn),
    .parOut(parOut), .leftOut(leftOut), .rightOut(rightOut)
  );

  function automatic logic [W-1:0] packModel();
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) v[i] = mdl[i];
    return v;
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit c, logic [1:0] m, logic [W-1:0] p, bit li, bit ri, string tag);
    @(negedge clk);
    clear = c; mode = m; parIn = p; leftIn = li; rightIn = ri;
    @(posedge clk);
    #1;
    if (c) begin
      mdl.delete();
      for (int i = 0; i < W; i++) mdl.push_back(1'b0);
    end else begin
      case (m)
        2'b01: begin void'(mdl.pop_front()); mdl.push_back(li); end
        2'b10: begin void'(mdl.pop_back()); mdl.push_front(ri); end
        2'b11: begin
          mdl.delete();
          for (int i = 0; i < W; i++) mdl.push_back(p[i]);
        end
        default: ;
      endcase
    end
    check(tag, parOut, packModel());
    check("R6 leftOut", {{(W-1){1'b0}}, leftOut}, {{(W-1){1'b0}}, mdl[W-1]});
    check("R6 rightOut", {{(W-1){1'b0}}, rightOut}, {{(W-1){1'b0}}, mdl[0]});
  endtask

  function automatic string tagFor(bit c, logic [1:0] m);
    if (c) return "R5";
    case (m)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  initial begin
    #(20 * 100000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // Reset state: clear with a load request pending (R5)
    step(1, 2'b11, 4'hF, 1, 1, "R5 reset");
    // R7: keep after clear stays zero
    step(0, 2'b00, 4'hF, 1, 1, "R7");
    step(0, 2'b00, 4'hA, 1, 1, "R7");
    // R4 load, R1 keep
    step(0, 2'b11, 4'h9, 0, 0, "R4");
    step(0, 2'b00, 4'h6, 1, 1, "R1");
    step(0, 2'b00, 4'h0, 0, 1, "R1");
    // R2 toward bit 0 with leftIn high then low
    step(0, 2'b01, 4'h0, 1, 0, "R2");
    step(0, 2'b01, 4'hF, 0, 1, "R2");
    step(0, 2'b01, 4'h0, 1, 1, "R2");
    // R3 toward the top with rightIn patterns
    step(0, 2'b10, 4'h0, 0, 1, "R3");
    step(0, 2'b10, 4'hF, 1, 0, "R3");
    step(0, 2'b10, 4'h0, 0, 1, "R3");
    // R5: clear coinciding with every mode over nonzero contents
    for (int m = 0; m < 4; m++) begin
      step(0, 2'b11, 4'hD, 0, 0, "R4");
      step(1, m[1:0], 4'hF, 1, 1, "R5 with mode");
    end
    // R2 chain: walk a one from leftIn to rightOut over W shifts
    step(0, 2'b01, 4'h0, 1, 0, "R2 chain");
    for (int i = 1; i < W; i++) step(0, 2'b01, 4'h0, 0, 0, "R2 chain");
    // Random run
    for (int n = 0; n < 400; n++) begin
      bit c;
      logic [1:0] m;
      c = ($urandom_range(0, 9) == 0);
      m = 2'($urandom);
      step(c, m, 4'($urandom), 1'($urandom), 1'($urandom), tagFor(c, m));
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule